// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital half of an eight-input, ten-bit successive-approximation converter. Software programs a six-bit control word that holds the input select, a run request, a sticky completion flag and a power-up enable. The block drives the analog multiplexer select, a one-clock track-and-hold strobe and a trial code for a resistor-ladder DAC. It reads a single comparator bit back, and from those bits it builds the result by binary search, most significant bit first.

Every conversion takes eleven converter clocks: one for track-and-hold and one for each result bit. The result goes into two registers, an eight-bit upper part and a two-bit lower part. The same clock edge sets the completion flag and drops the run request. The completion flag, gated by an external interrupt-enable input, forms the interrupt request. After the enable rises, the block holds off the first conversion for a programmable number of clocks. A run request made during that interval waits and then starts.

Top module: `adc_sar_ctrl`

## Requirements
- R1: While the synchronous active-low reset is low, the control word, both result registers and the sequencer clear to zero. After reset, ctl_rdata reads 0, irq is 0 and sh_strobe is 0.
- R2: The control word layout is: bits [2:0] input select (code n picks input n and appears on chan_sel), bit 3 run request, bit 4 completion flag, bit 5 enable. ctl_rdata returns the same layout.
- R3: With the setup interval already elapsed, a run request written on edge W launches on edge W+1. The conversion occupies 11 clocks, so the completion flag reads 1 after edge W+12.
- R4: The first clock of a conversion raises sh_strobe for exactly one cycle. Each of the ten clocks after it tries one bit, MSB first, and keeps that bit when cmp_in is 1 (input at or above dac_code). With an ideal comparator the result equals the input value.
- R5: res_hi holds result bits [9:2] and res_lo holds bits [1:0].
- R6: On the edge that ends a conversion, the result registers load, the completion flag sets and the run request clears, all together.
- R7: The completion flag is sticky. A control write with bit 4 at 0 clears it. A write with bit 4 at 1 leaves it unchanged.
- R8: irq is 1 exactly while irq_en and the completion flag are both 1.
- R9: After the enable goes from 0 to 1, no conversion launches until SETUP_CLKS clocks have passed. A run request made earlier stays pending and launches on the first edge after the interval ends. While the enable stays high, later conversions wait for no setup interval.
- R10: While a conversion runs, writes do not change the input select or the run request.
- R11: Writing the enable to 0 aborts any conversion. The run request clears, the completion flag does not set and the result registers keep their old values.
- R12: A flag-clearing write on the completion edge loses: the flag ends up set. An enable-clearing write on the completion edge wins: the flag stays clear and the results are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 6 | Control word write data |
| ctl_rdata | output | 6 | Control word read-back |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request |
| chan_sel | output | 3 | Analog multiplexer select |
| sh_strobe | output | 1 | Track-and-hold strobe |
| dac_code | output | 10 | Trial code to the DAC |
| cmp_in | input | 1 | Comparator: input at or above DAC level |
| res_hi | output | 8 | Result bits [9:2] |
| res_lo | output | 2 | Result bits [1:0] |

## Verification
Two events can land on the same edge: a conversion finishing, and a software write that touches the completion flag or the enable. The bench times a flag-clearing write, and in a separate run an enable-clearing write, so that each lands exactly on the twelfth edge after the run request. It then reads the flag and the result registers back against R12. Each outcome is judged against a conversion value that differs from the stored one, so a stale or wrongly loaded result is visible.

// File: rtl/adc_sar_pkg.sv
package adc_sar_pkg;
   typedef enum logic [1:0] {
      SAR_IDLE   = 2'd0,
      SAR_SAMPLE = 2'd1,
      SAR_BITS   = 2'd2
   } sar_state_e;

   localparam int CTL_W     = 6;
   localparam int CTL_START = 3;
   localparam int CTL_EOC   = 4;
   localparam int CTL_EN    = 5;
endpackage

// File: rtl/adc_setup_timer.sv
module adc_setup_timer #(
   parameter int SETUP_CLKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic ready
);
   generate
      if (SETUP_CLKS == 0) begin : g_no_wait
         assign ready = en;
      end else begin : g_wait
         localparam int CNT_W = $clog2(SETUP_CLKS + 1);
         localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SETUP_CLKS);
         logic [CNT_W-1:0] cnt;

         always_ff @(posedge clk) begin
            if (!rst_n || !en) cnt <= '0;
            else if (cnt != LIMIT) cnt <= cnt + 1'b1;
         end

         assign ready = en && (cnt == LIMIT);

         // R9
         ready_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ready) |-> $past(en));
      end
   endgenerate
endmodule

// File: rtl/adc_sar_engine.sv
module adc_sar_engine
   import adc_sar_pkg::*;
#(
   parameter int RES_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic             abort,
   input  logic             cmp_in,
   output logic             sh_strobe,
   output logic [RES_W-1:0] dac_code,
   output logic             busy,
   output logic             last,
   output logic [RES_W-1:0] result
);
   localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;
   localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RES_W - 1);

   sar_state_e       state;
   logic [IDX_W-1:0] idx;
   logic [RES_W-1:0] acc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= SAR_IDLE;
         idx   <= '0;
         acc   <= '0;
      end else if (abort) begin
         state <= SAR_IDLE;
      end else begin
         unique case (state)
            SAR_IDLE: if (go) begin
               state <= SAR_SAMPLE;
               acc   <= '0;
            end
            SAR_SAMPLE: begin
               state <= SAR_BITS;
               idx   <= TOP_IDX;
            end
            SAR_BITS: begin
               acc[idx] <= cmp_in;
               if (idx == '0) state <= SAR_IDLE;
               else idx <= idx - 1'b1;
            end
            default: state <= SAR_IDLE;
         endcase
      end
   end

   assign sh_strobe = (state == SAR_SAMPLE);
   assign busy      = (state != SAR_IDLE);
   assign last      = (state == SAR_BITS) && (idx == '0);

   generate
      for (genvar i = 0; i < RES_W; i++) begin : g_bit
         assign dac_code[i] = acc[i] | ((state == SAR_BITS) && (idx == IDX_W'(i)));
         if (i == 0) begin : g_lsb
            assign result[i] = last ? cmp_in : acc[i];
         end else begin : g_upper
            assign result[i] = acc[i];
         end
      end
   endgenerate

   // R4
   sample_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sh_strobe |=> !sh_strobe);
   // R3
   launch_to_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && go && !abort) |=> sh_strobe);
endmodule

// File: rtl/adc_ctl_regs.sv
module adc_ctl_regs
   import adc_sar_pkg::*;
#(
   parameter int CHAN_W = 3,
   parameter int RES_W  = 10,
   parameter int HI_W   = 8,
   localparam int LO_W  = RES_W - HI_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [CTL_W-1:0]  wdata,
   input  logic              busy,
   input  logic              last,
   input  logic [RES_W-1:0]  result,
   output logic              abort,
   output logic              en,
   output logic              start,
   output logic              eoc,
   output logic [CHAN_W-1:0] chan,
   output logic [HI_W-1:0]   res_hi,
   output logic [LO_W-1:0]   res_lo
);
   logic commit;

   assign abort  = wr && !wdata[CTL_EN];
   assign commit = last && !abort;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en     <= 1'b0;
         start  <= 1'b0;
         eoc    <= 1'b0;
         chan   <= '0;
         res_hi <= '0;
         res_lo <= '0;
      end else begin
         if (wr) en <= wdata[CTL_EN];

         if (abort || commit) start <= 1'b0;
         else if (wr && !busy) start <= wdata[CTL_START];

         if (wr && !busy) chan <= wdata[CHAN_W-1:0];

         if (commit) eoc <= 1'b1;
         else if (wr && !wdata[CTL_EOC]) eoc <= 1'b0;

         if (commit) {res_hi, res_lo} <= result;
      end
   end

   // R6
   done_same_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (eoc && !start));
   // R10
   chan_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(chan));
   // R10
   start_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> start);
   // R7
   eoc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eoc && !(wr && !wdata[CTL_EOC])) |=> eoc);
endmodule

// File: rtl/adc_sar_ctrl.sv
module adc_sar_ctrl
   import adc_sar_pkg::*;
#(
   parameter int CHAN_W     = 3,
   parameter int RES_W      = 10,
   parameter int HI_W       = 8,
   parameter int SETUP_CLKS = 4,
   localparam int LO_W      = RES_W - HI_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [CTL_W-1:0]  ctl_wdata,
   output logic [CTL_W-1:0]  ctl_rdata,
   input  logic              irq_en,
   output logic              irq,
   output logic [CHAN_W-1:0] chan_sel,
   output logic              sh_strobe,
   output logic [RES_W-1:0]  dac_code,
   input  logic              cmp_in,
   output logic [HI_W-1:0]   res_hi,
   output logic [LO_W-1:0]   res_lo
);
   generate
      if (CHAN_W != CTL_START) begin : g_bad_chan
         $error("CHAN_W must fill the field below the run request bit");
      end
      if (RES_W < 2) begin : g_bad_res
         $error("RES_W must be at least 2");
      end
      if (HI_W < 1 || HI_W >= RES_W) begin : g_bad_split
         $error("HI_W must lie between 1 and RES_W-1");
      end
   endgenerate

   logic             ready, busy, last, abort;
   logic             en, start, eoc;
   logic [RES_W-1:0] result;

   adc_setup_timer #(.SETUP_CLKS(SETUP_CLKS)) u_timer (
      .clk(clk), .rst_n(rst_n), .en(en), .ready(ready)
   );

   adc_sar_engine #(.RES_W(RES_W)) u_engine (
      .clk(clk), .rst_n(rst_n), .go(start && ready), .abort(abort),
      .cmp_in(cmp_in), .sh_strobe(sh_strobe), .dac_code(dac_code),
      .busy(busy), .last(last), .result(result)
   );

   adc_ctl_regs #(.CHAN_W(CHAN_W), .RES_W(RES_W), .HI_W(HI_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata),
      .busy(busy), .last(last), .result(result), .abort(abort),
      .en(en), .start(start), .eoc(eoc), .chan(chan_sel),
      .res_hi(res_hi), .res_lo(res_lo)
   );

   always_comb begin
      ctl_rdata                 = '0;
      ctl_rdata[CHAN_W-1:0]     = chan_sel;
      ctl_rdata[CTL_START]      = start;
      ctl_rdata[CTL_EOC]        = eoc;
      ctl_rdata[CTL_EN]         = en;
   end

   assign irq = irq_en && eoc;

   // R9
   setup_before_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sh_strobe) |-> $past(ready));
   // R11
   abort_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !ctl_wdata[CTL_EN] && !eoc) |=> !eoc);
endmodule

// File: tb/tb_adc_sar_ctrl.sv
module tb_adc_sar_ctrl;
   localparam int SETUP = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_wr = 1'b0;
   logic [5:0] ctl_wdata = '0;
   logic [5:0] ctl_rdata;
   logic       irq_en = 1'b0;
   logic       irq;
   logic [2:0] chan_sel;
   logic       sh_strobe;
   logic [9:0] dac_code;
   logic       cmp_in;
   logic [7:0] res_hi;
   logic [1:0] res_lo;

   logic [9:0] vin [8];
   int total = 0;
   int bad = 0;
   int sh_cnt = 0;
   int sh_chan = 0;

   always #2 clk = ~clk;

   assign cmp_in = (vin[chan_sel] >= dac_code);

   adc_sar_ctrl #(.SETUP_CLKS(SETUP)) dut (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .ctl_rdata(ctl_rdata), .irq_en(irq_en), .irq(irq), .chan_sel(chan_sel),
      .sh_strobe(sh_strobe), .dac_code(dac_code), .cmp_in(cmp_in),
      .res_hi(res_hi), .res_lo(res_lo)
   );

   always @(posedge clk) if (sh_strobe) begin
      sh_cnt  <= sh_cnt + 1;
      sh_chan <= int'(chan_sel);
   end

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] d);
      @(negedge clk);
      ctl_wr = 1'b1;
      ctl_wdata = d;
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   task automatic wait_eoc(output int n);
      n = 0;
      while (!ctl_rdata[4] && n < 40) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic conv(input int ch, input int exp_n, input string tag);
      int n;
      int v;
      v = int'(vin[ch]);
      sh_cnt = 0;
      wr({3'b101, 3'(ch)});
      wait_eoc(n);
      chk({tag, " R3 latency"}, n, exp_n);
      chk({tag, " R5 res_hi"}, int'(res_hi), v >> 2);
      chk({tag, " R5 res_lo"}, int'(res_lo), v & 3);
      chk({tag, " R6 start cleared"}, int'(ctl_rdata[3]), 0);
      chk({tag, " R4 one strobe"}, sh_cnt, 1);
      chk({tag, " R2 channel at strobe"}, sh_chan, ch);
      chk({tag, " R8 irq"}, int'(irq), int'(irq_en));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int n;
      for (int i = 0; i < 8; i++) vin[i] = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 rdata", int'(ctl_rdata), 0);
      chk("R1 irq", int'(irq), 0);
      chk("R1 strobe", int'(sh_strobe), 0);
      chk("R1 result", int'({res_hi, res_lo}), 0);
      rst_n = 1'b1;

      // R2 readback of the field layout (enable + select only)
      wr(6'b100_011);
      chk("R2 rdata", int'(ctl_rdata), 6'b100_011);
      chk("R2 chan_sel", int'(chan_sel), 3);
      wr(6'b000_000);

      // R9 first conversion after enable waits the setup interval
      vin[0] = 10'd700;
      conv(0, SETUP + 12, "setup");

      // R4 R5 sweep of all inputs and value patterns with enable held
      for (int ch = 0; ch < 8; ch++) begin
         for (int k = 0; k < 4; k++) begin
            case (k)
               0: vin[ch] = 10'(ch * 127 + 3);
               1: vin[ch] = 10'(1023 - ch * 37);
               2: vin[ch] = (ch % 2 == 0) ? 10'd0 : 10'd1023;
               default: vin[ch] = 10'(512 - ch);
            endcase
            conv(ch, 12, "sweep");
         end
      end

      // R8 R7 interrupt gating and sticky flag
      irq_en = 1'b1;
      @(negedge clk);
      chk("R8 irq set", int'(irq), 1);
      irq_en = 1'b0;
      @(negedge clk);
      chk("R8 irq masked", int'(irq), 0);
      irq_en = 1'b1;
      wr(6'b110_111);
      chk("R7 write 1 keeps flag", int'(ctl_rdata[4]), 1);
      chk("R8 irq still set", int'(irq), 1);
      wr(6'b100_111);
      chk("R7 write 0 clears flag", int'(ctl_rdata[4]), 0);
      chk("R8 irq rearmed", int'(irq), 0);

      // R10 writes during a conversion are ignored
      vin[2] = 10'd300;
      vin[5] = 10'd900;
      sh_cnt = 0;
      wr(6'b101_010);
      repeat (3) @(negedge clk);
      wr(6'b101_101);
      chk("R10 select frozen", int'(ctl_rdata[2:0]), 2);
      wait_eoc(n);
      chk("R10 result of first input", int'({res_hi, res_lo}), 300);
      repeat (20) @(negedge clk);
      chk("R10 no second launch", sh_cnt, 1);
      chk("R10 start low", int'(ctl_rdata[3]), 0);

      // R11 abort by clearing the enable
      vin[6] = 10'd100;
      sh_cnt = 0;
      wr(6'b101_110);
      repeat (5) @(negedge clk);
      wr(6'b000_110);
      repeat (15) @(negedge clk);
      chk("R11 flag not set", int'(ctl_rdata[4]), 0);
      chk("R11 start cleared", int'(ctl_rdata[3]), 0);
      chk("R11 result kept", int'({res_hi, res_lo}), 300);
      chk("R11 no relaunch", sh_cnt, 1);
      conv(6, SETUP + 12, "reenable R9");

      // R9 pending run request during the setup interval
      vin[1] = 10'd555;
      sh_cnt = 0;
      wr(6'b000_000);
      wr(6'b100_001);
      wr(6'b101_001);
      wait_eoc(n);
      chk("R9 pending latency", n, SETUP + 10);
      chk("R9 pending result", int'({res_hi, res_lo}), 555);

      // R12 flag-clear write on the completion edge: set wins
      vin[4] = 10'd613;
      wr(6'b101_100);
      repeat (10) @(negedge clk);
      wr(6'b100_100);
      chk("R12 flag set wins", int'(ctl_rdata[4]), 1);
      chk("R12 result loaded", int'({res_hi, res_lo}), 613);
      chk("R12 start low", int'(ctl_rdata[3]), 0);

      // R12 enable-clear write on the completion edge: abort wins
      vin[4] = 10'd99;
      wr(6'b101_100);
      repeat (10) @(negedge clk);
      wr(6'b000_100);
      chk("R12 abort wins flag", int'(ctl_rdata[4]), 0);
      chk("R12 abort keeps result", int'({res_hi, res_lo}), 613);
      chk("R12 abort start low", int'(ctl_rdata[3]), 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule